// File: doc/BRIEF.md
# Register Window Pointer Controller

This block holds the current window pointer and the invalid-window mask of a processor whose integer registers are arranged as a ring of overlapping windows. Each cycle it accepts at most one command: step the window down (save), step it up (restore), return from a trap, write the packed processor status word, or write the invalid-window mask. A move that would land on a window flagged in the mask is refused and a trap is requested instead. A return from trap is refused outright when traps are already enabled.

Results are registered. The new window pointer, the packed status word and the mask are visible from the cycle after the command. A trapping command raises `trap_req` for that one cycle and places its code on `trap_code`. The number of windows is a parameter from 2 to 32. Vectoring to the trap handler and interrupt selection belong to neighbouring blocks.

Top module: `regwin_ctrl`

## Requirements
- R1: Asynchronous active-low reset sets the window pointer to 0, the mask to 0, supervisor to 1, and every other writable status field to 0. `trap_req` is low.
- R2: Command code 1 (save) with the mask bit of the target window clear sets the pointer to the pointer minus 1. Window 0 wraps to window NWIN-1.
- R3: Command code 2 (restore) with the mask bit of the target window clear sets the pointer to the pointer plus 1. Window NWIN-1 wraps to window 0.
- R4: A save whose target window is masked requests a trap with code 0x05 and leaves the pointer unchanged.
- R5: A restore whose target window is masked requests a trap with code 0x06 and leaves the pointer unchanged.
- R6: Command code 3 (return from trap) while enable-traps (status bit 5) is 1 requests a trap with code 0x02 and changes no state.
- R7: A return from trap with enable-traps at 0 and an unmasked target sets enable-traps to 1, moves the pointer as a restore does, and copies previous-supervisor (bit 6) into supervisor (bit 7).
- R8: A return from trap with enable-traps at 0 and a masked target requests a trap with code 0x06 and still sets enable-traps to 1. The pointer and supervisor stay as they were.
- R9: Command code 4 (status write) with a window field below NWIN loads all writable fields of the status word: condition codes in bits 23:20, FP-enable in bit 12, interrupt level in bits 11:8, supervisor in bit 7, previous-supervisor in bit 6, enable-traps in bit 5 and the pointer in bits 4:0. Bits 31:24 always read the VERSION parameter. All other bits read 0.
- R10: A status write whose bits 4:0 are NWIN or greater requests a trap with code 0x02 and changes no state.
- R11: `trap_req` is high only in the cycle after a trapping command. Command code 0 (idle) changes no state and requests no trap.
- R12: Command code 5 (mask write) loads the mask from `wr_data[NWIN-1:0]` and ignores the upper bits. The mask reads back on `mask_rd`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cmd | input | 3 | Command: 0 idle, 1 save, 2 restore, 3 return from trap, 4 status write, 5 mask write |
| wr_data | input | 32 | Data for status and mask writes |
| cwp | output | 5 | Current window pointer |
| status_rd | output | 32 | Packed status word |
| mask_rd | output | NWIN | Invalid-window mask |
| trap_req | output | 1 | Trap request, one cycle per trapping command |
| trap_code | output | 8 | Trap type while `trap_req` is high, otherwise 0 |

## Verification
The hardest case to reach is a return from trap that fails the window check. It needs enable-traps at 0, a chosen previous-supervisor value that differs from supervisor, and a mask bit set exactly one window above the pointer. All of that can only be set through the ports. The stimulus first writes a status word with the pointer at the top window, enable-traps clear and previous-supervisor set. It then masks window 0, so the wrapped target of the return is the masked one. The check is that enable-traps rises while the pointer and supervisor stay where they were.

// File: rtl/regwin_pkg.sv
package regwin_pkg;

   localparam int CWP_W  = 5;
   localparam int WORD_W = 32;

   typedef enum logic [2:0] {
      CMD_IDLE    = 3'd0,
      CMD_SAVE    = 3'd1,
      CMD_RESTORE = 3'd2,
      CMD_RETT    = 3'd3,
      CMD_WSTAT   = 3'd4,
      CMD_WMASK   = 3'd5
   } regwin_cmd_e;

   localparam logic [7:0] TT_NONE    = 8'h00;
   localparam logic [7:0] TT_ILLEGAL = 8'h02;
   localparam logic [7:0] TT_WIN_OVF = 8'h05;
   localparam logic [7:0] TT_WIN_UNF = 8'h06;

   typedef struct packed {
      logic [3:0] icc;
      logic       fpen;
      logic [3:0] lvl;
      logic       sup;
      logic       psup;
      logic       trapen;
   } regwin_stat_t;

endpackage

// File: rtl/regwin_step.sv
module regwin_step #(
   parameter int NWIN  = 8,
   parameter int CWP_W = 5
) (
   input  logic [CWP_W-1:0] cur,
   output logic [CWP_W-1:0] down,
   output logic [CWP_W-1:0] up
);
   localparam int IW = (NWIN > 1) ? $clog2(NWIN) : 1;
   localparam logic [CWP_W-1:0] LAST = CWP_W'(NWIN - 1);

   generate
      if ((1 << IW) == NWIN) begin : g_pow2
         logic [IW-1:0] dn_lo, up_lo;
         assign dn_lo = cur[IW-1:0] - IW'(1);
         assign up_lo = cur[IW-1:0] + IW'(1);
         if (IW == CWP_W) begin : g_full
            assign down = dn_lo;
            assign up   = up_lo;
         end else begin : g_pad
            assign down = {{(CWP_W-IW){1'b0}}, dn_lo};
            assign up   = {{(CWP_W-IW){1'b0}}, up_lo};
         end
      end else begin : g_cmp
         assign down = (cur == '0)   ? LAST : cur - CWP_W'(1);
         assign up   = (cur == LAST) ? '0   : cur + CWP_W'(1);
      end
   endgenerate
endmodule

// File: rtl/regwin_probe.sv
module regwin_probe #(
   parameter int NWIN  = 8,
   parameter int CWP_W = 5
) (
   input  logic [NWIN-1:0]  mask,
   input  logic [CWP_W-1:0] idx,
   output logic             hit
);
   always_comb begin
      hit = 1'b0;
      for (int i = 0; i < NWIN; i++) begin
         if (idx == CWP_W'(i)) hit = mask[i];
      end
   end
endmodule

// File: rtl/regwin_status_io.sv
module regwin_status_io
   import regwin_pkg::*;
#(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'h15
) (
   input  regwin_stat_t      st,
   input  logic [CWP_W-1:0]  cur,
   input  logic [WORD_W-1:0] wdata,
   output logic [WORD_W-1:0] word,
   output regwin_stat_t      wst,
   output logic [CWP_W-1:0]  wcwp,
   output logic              wok
);
   localparam logic [CWP_W:0] NW = (CWP_W+1)'(NWIN);

   assign word = {VERSION, st.icc, 7'd0, st.fpen, st.lvl,
                  st.sup, st.psup, st.trapen, cur};

   assign wst.icc    = wdata[23:20];
   assign wst.fpen   = wdata[12];
   assign wst.lvl    = wdata[11:8];
   assign wst.sup    = wdata[7];
   assign wst.psup   = wdata[6];
   assign wst.trapen = wdata[5];
   assign wcwp       = wdata[4:0];
   assign wok        = ({1'b0, wdata[4:0]} < NW);
endmodule

// File: rtl/regwin_ctrl.sv
module regwin_ctrl
   import regwin_pkg::*;
#(
   parameter int         NWIN    = 8,
   parameter logic [7:0] VERSION = 8'h15
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [31:0]       wr_data,
   output logic [4:0]        cwp,
   output logic [31:0]       status_rd,
   output logic [NWIN-1:0]   mask_rd,
   output logic              trap_req,
   output logic [7:0]        trap_code
);
   generate
      if (NWIN < 2 || NWIN > (1 << CWP_W)) begin : g_bad_nwin
         $error("regwin_ctrl: NWIN must lie in 2..32");
      end
   endgenerate

   localparam regwin_stat_t STAT_RST = '{icc: 4'd0, fpen: 1'b0, lvl: 4'd0,
                                         sup: 1'b1, psup: 1'b0, trapen: 1'b0};

   logic [CWP_W-1:0] cwp_q, cwp_d;
   logic [NWIN-1:0]  mask_q, mask_d;
   regwin_stat_t     st_q, st_d;
   logic             trap_q, trap_d;
   logic [7:0]       code_q, code_d;

   logic [CWP_W-1:0] tgt_down, tgt_up, w_cwp;
   logic             hit_down, hit_up, w_ok;
   regwin_stat_t     w_st;
   regwin_cmd_e      op;

   assign op = regwin_cmd_e'(cmd);

   regwin_step #(.NWIN(NWIN), .CWP_W(CWP_W)) u_step (
      .cur (cwp_q),
      .down(tgt_down),
      .up  (tgt_up)
   );

   regwin_probe #(.NWIN(NWIN), .CWP_W(CWP_W)) u_probe_dn (
      .mask(mask_q),
      .idx (tgt_down),
      .hit (hit_down)
   );

   regwin_probe #(.NWIN(NWIN), .CWP_W(CWP_W)) u_probe_up (
      .mask(mask_q),
      .idx (tgt_up),
      .hit (hit_up)
   );

   regwin_status_io #(.NWIN(NWIN), .VERSION(VERSION)) u_sio (
      .st   (st_q),
      .cur  (cwp_q),
      .wdata(wr_data),
      .word (status_rd),
      .wst  (w_st),
      .wcwp (w_cwp),
      .wok  (w_ok)
   );

   always_comb begin
      cwp_d  = cwp_q;
      mask_d = mask_q;
      st_d   = st_q;
      trap_d = 1'b0;
      code_d = TT_NONE;
      unique case (op)
         CMD_SAVE: begin
            if (hit_down) begin
               trap_d = 1'b1;
               code_d = TT_WIN_OVF;
            end else begin
               cwp_d = tgt_down;
            end
         end
         CMD_RESTORE: begin
            if (hit_up) begin
               trap_d = 1'b1;
               code_d = TT_WIN_UNF;
            end else begin
               cwp_d = tgt_up;
            end
         end
         CMD_RETT: begin
            if (st_q.trapen) begin
               trap_d = 1'b1;
               code_d = TT_ILLEGAL;
            end else begin
               st_d.trapen = 1'b1;
               if (hit_up) begin
                  trap_d = 1'b1;
                  code_d = TT_WIN_UNF;
               end else begin
                  cwp_d    = tgt_up;
                  st_d.sup = st_q.psup;
               end
            end
         end
         CMD_WSTAT: begin
            if (!w_ok) begin
               trap_d = 1'b1;
               code_d = TT_ILLEGAL;
            end else begin
               st_d  = w_st;
               cwp_d = w_cwp;
            end
         end
         CMD_WMASK: mask_d = wr_data[NWIN-1:0];
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cwp_q  <= '0;
         mask_q <= '0;
         st_q   <= STAT_RST;
         trap_q <= 1'b0;
         code_q <= TT_NONE;
      end else begin
         cwp_q  <= cwp_d;
         mask_q <= mask_d;
         st_q   <= st_d;
         trap_q <= trap_d;
         code_q <= code_d;
      end
   end

   assign cwp       = cwp_q;
   assign mask_rd   = mask_q;
   assign trap_req  = trap_q;
   assign trap_code = code_q;
endmodule

// File: rtl/regwin_chk.sv
module regwin_chk #(
   parameter int NWIN = 8
) (
   input logic        clk,
   input logic        rst_n,
   input logic [2:0]  cmd,
   input logic [31:0] wr_data,
   input logic [4:0]  cwp,
   input logic [31:0] status_rd,
   input logic        trap_req,
   input logic [7:0]  trap_code
);
   localparam logic [5:0] NW   = 6'(NWIN);
   localparam logic [4:0] LAST = 5'(NWIN - 1);

   logic seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) seen <= 1'b0;
      else        seen <= 1'b1;
   end

   p_cwp_range_r9: assert property (@(posedge clk) disable iff (!rst_n)
      {1'b0, cwp} < NW);

   p_trap_freeze_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && trap_req) |-> (cwp == $past(cwp)));

   p_trap_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
      trap_req |-> (trap_code == 8'h02 || trap_code == 8'h05 || trap_code == 8'h06));

   p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd0) |-> (!trap_req && $stable(cwp) && $stable(status_rd)));

   p_save_move_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd1 && !trap_req) |->
      (cwp == (($past(cwp) == 5'd0) ? LAST : $past(cwp) - 5'd1)));

   p_restore_move_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd2 && !trap_req) |->
      (cwp == (($past(cwp) == LAST) ? 5'd0 : $past(cwp) + 5'd1)));

   p_rett_illegal_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd3 && $past(status_rd[5])) |->
      (trap_req && trap_code == 8'h02 && $stable(status_rd)));

   p_rett_enable_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd3) |-> status_rd[5]);

   p_wstat_range_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seen && $past(cmd) == 3'd4 && {1'b0, $past(wr_data[4:0])} >= NW) |->
      (trap_req && $stable(status_rd)));
endmodule

bind regwin_ctrl regwin_chk #(.NWIN(NWIN)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .cmd      (cmd),
   .wr_data  (wr_data),
   .cwp      (cwp),
   .status_rd(status_rd),
   .trap_req (trap_req),
   .trap_code(trap_code)
);

// File: tb/sim_regwin_ctrl.sv
`timescale 1ns/1ps
module sim_regwin_ctrl;
   localparam int NWIN = 8;
   localparam int NV   = 15;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [2:0]  cmd = 3'd0;
   logic [31:0] wr_data = '0;
   logic [4:0]  cwp;
   logic [31:0] status_rd;
   logic [NWIN-1:0] mask_rd;
   logic        trap_req;
   logic [7:0]  trap_code;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   regwin_ctrl #(.NWIN(NWIN), .VERSION(8'h15)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .wr_data(wr_data), .cwp(cwp),
      .status_rd(status_rd), .mask_rd(mask_rd), .trap_req(trap_req),
      .trap_code(trap_code)
   );

   // {cmd[3], data[32], cwp[5], trap[1], code[8], status[32]}
   localparam logic [80:0] VEC [0:NV-1] = '{
      {3'd1, 32'h0,        5'd7, 1'b0, 8'h00, 32'h1500_0087}, // R2 wrap 0->7
      {3'd1, 32'h0,        5'd6, 1'b0, 8'h00, 32'h1500_0086}, // R2
      {3'd2, 32'h0,        5'd7, 1'b0, 8'h00, 32'h1500_0087}, // R3
      {3'd2, 32'h0,        5'd0, 1'b0, 8'h00, 32'h1500_0080}, // R3 wrap 7->0
      {3'd5, 32'h80,       5'd0, 1'b0, 8'h00, 32'h1500_0080}, // R12
      {3'd1, 32'h0,        5'd0, 1'b1, 8'h05, 32'h1500_0080}, // R4
      {3'd5, 32'h02,       5'd0, 1'b0, 8'h00, 32'h1500_0080}, // R12
      {3'd2, 32'h0,        5'd0, 1'b1, 8'h06, 32'h1500_0080}, // R5
      {3'd5, 32'h0,        5'd0, 1'b0, 8'h00, 32'h1500_0080}, // R12
      {3'd4, 32'h0000_0009,5'd0, 1'b1, 8'h02, 32'h1500_0080}, // R10
      {3'd4, 32'h00F0_1A43,5'd3, 1'b0, 8'h00, 32'h15F0_1A43}, // R9
      {3'd3, 32'h0,        5'd4, 1'b0, 8'h00, 32'h15F0_1AE4}, // R7
      {3'd3, 32'h0,        5'd4, 1'b1, 8'h02, 32'h15F0_1AE4}, // R6
      {3'd4, 32'hFF00_0007,5'd7, 1'b0, 8'h00, 32'h1500_0007}, // R9 version kept
      {3'd0, 32'h0,        5'd7, 1'b0, 8'h00, 32'h1500_0007}  // R11
   };

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic do_cmd(input logic [2:0] c, input logic [31:0] d);
      cmd = c;
      wr_data = d;
      @(negedge clk);
      cmd = 3'd0;
      wr_data = '0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   endtask

   initial begin
      #(20 * 5000);
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      check("R1 cwp",    32'(cwp), 32'd0);
      check("R1 status", status_rd, 32'h1500_0080);
      check("R1 mask",   32'(mask_rd), 32'd0);
      check("R1 trap",   32'(trap_req), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);

      for (int i = 0; i < NV; i++) begin
         do_cmd(VEC[i][80:78], VEC[i][77:46]);
         check($sformatf("vec%0d cwp", i),    32'(cwp),       32'(VEC[i][45:41]));
         check($sformatf("vec%0d trap", i),   32'(trap_req),  32'(VEC[i][40]));
         check($sformatf("vec%0d code", i),   32'(trap_code), 32'(VEC[i][39:32]));
         check($sformatf("vec%0d status", i), status_rd,      VEC[i][31:0]);
      end

      // R8: return from trap into masked window (7 -> 0 wrap)
      do_cmd(3'd4, 32'h0000_0047);
      do_cmd(3'd5, 32'h0000_0001);
      check("R12 mask readback", 32'(mask_rd), 32'h01);
      do_cmd(3'd3, 32'h0);
      check("R8 trap",   32'(trap_req),  32'd1);
      check("R8 code",   32'(trap_code), 32'h06);
      check("R8 cwp",    32'(cwp),       32'd7);
      check("R8 status", status_rd,      32'h1500_0067);
      do_cmd(3'd0, 32'h0);
      check("R11 strobe drops", 32'(trap_req), 32'd0);
      check("R11 code clears",  32'(trap_code), 32'd0);

      // R12: upper data bits ignored
      do_cmd(3'd5, 32'hFFFF_FF05);
      check("R12 mask upper ignored", 32'(mask_rd), 32'h05);
      do_cmd(3'd1, 32'h0);
      check("R12 save unmasked cwp", 32'(cwp), 32'd6);
      check("R12 save unmasked trap", 32'(trap_req), 32'd0);

      // R1: reset in the middle of a run
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 rerun cwp",    32'(cwp), 32'd0);
      check("R1 rerun status", status_rd, 32'h1500_0080);
      check("R1 rerun mask",   32'(mask_rd), 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      finish_run();
   end
endmodule